// File: doc/BRIEF.md
# Latched Channel-Select Controller

This block drives the close signals of an eight-way analog switch array from a small parallel control port. A channel code and an enable bit are taken in through level-sensitive holding registers. These registers pass their inputs through while the active-low write strobe is low, and they keep the last value once the strobe returns high. The held values are decoded into a vector of close lines. With the default parameters, the vector is one-hot for single-ended use. In pair mode, each of four differential pairs drives two lines together.

Any move from one closed selection to a different closed selection passes through a programmable dead interval in which every switch is open. Opening a switch has no delay. A disable, or the active-low clear input, opens every switch on the next clock.

A timing monitor measures the write strobe, setup, hold and clear pulse in clock cycles. It raises a sticky error flag when any of them falls short. The whole block runs on one system clock and has a synchronous active-high reset.

Top module: `chsel_ctrl`

## Requirements
- R1: In single-ended mode (PAIR_MODE=0), a held enable of 1 with held code k closes only bit k of `sw_close`, so code 0 closes bit 0 and code 7 closes bit 7.
- R2: In pair mode (PAIR_MODE=1), the 2-bit held code k closes exactly bits k and k+4 of `sw_close`, and no other bits.
- R3: A held enable of 0 opens every switch, whatever the code. If `wr_n` and `sel_en` are both sampled low at a clock edge, `sw_close` is all zero two cycles later, with no dead interval.
- R4: While `wr_n` is sampled low, the holding registers follow `sel_addr` and `sel_en` on every clock. The outputs track the live inputs, with a latency of two cycles plus any dead interval.
- R5: The values sampled on the last clock with `wr_n` low are kept after `wr_n` rises. Changes to `sel_addr` or `sel_en` while `wr_n` stays high do not alter `sw_close`.
- R6: `clr_n` sampled low clears the held enable and opens every switch two cycles later, even while `wr_n` is low. Once `clr_n` is released with `wr_n` high, all switches stay open until the next write.
- R7: A change between two different non-empty selections holds `sw_close` at all zero for exactly DEAD_CYCLES cycles before the new selection closes. In pair mode, a code change that maps to the same pair causes no gap.
- R8: A move from an all-open state to a non-empty selection has no gap. The switch closes two cycles after the enabling sample.
- R9: `timing_err` sets if `wr_n` rises after fewer than T_WR consecutive low samples.
- R10: `timing_err` sets if `sel_addr` and `sel_en` were not constant for at least T_SU samples ending with the last low sample of `wr_n`.
- R11: `timing_err` sets if `sel_addr` or `sel_en` differs from the captured value in any of the T_HD samples starting at the edge where `wr_n` is first seen high.
- R12: `timing_err` sets if `clr_n` rises after fewer than T_RS consecutive low samples.
- R13: `rst` clears the outputs and the held state to zero. `timing_err` stays set until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_addr | input | AW (3, or 2 in pair mode) | Channel or pair code |
| sel_en | input | 1 | Enable: 1 allows a switch to close |
| wr_n | input | 1 | Active-low write strobe: registers pass through while low |
| clr_n | input | 1 | Active-low clear of the held state |
| sw_close | output | N_SW (8) | Close line per switch |
| timing_err | output | 1 | Sticky control-timing violation flag |

## Verification
A sample taken at a clock edge is held one edge later and reaches `sw_close` at the edge after that. The bench therefore drives inputs on falling edges and reads closes no earlier than the second falling edge that follows. A selection change that needs a gap adds DEAD_CYCLES further cycles. The bench counts the zero cycles on each falling edge, with the write strobe held low long enough to cover both latency and gap. The error flag is read two edges after the strobe or clear rises, since the monitor judges a violation on the edge where the rise is first sampled.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  function automatic int code_width(input int n_sw, input int pair_mode);
    return (pair_mode != 0) ? $clog2(n_sw / 2) : $clog2(n_sw);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/chsel_hold.sv
module chsel_hold #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] sel_addr,
  input  logic          sel_en,
  input  logic          wr_n,
  input  logic          clr_n,
  output logic [AW-1:0] held_addr,
  output logic          held_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_addr <= '0;
      held_en   <= 1'b0;
    end else if (!clr_n) begin
      held_addr <= '0;
      held_en   <= 1'b0;
    end else if (!wr_n) begin
      held_addr <= sel_addr;
      held_en   <= sel_en;
    end
  end

endmodule

// File: rtl/chsel_decode.sv
module chsel_decode #(
  parameter int N_SW      = 8,
  parameter int PAIR_MODE = 0,
  parameter int AW        = 3
) (
  input  logic [AW-1:0]   held_addr,
  input  logic            held_en,
  output logic [N_SW-1:0] want
);

  localparam int N_SEL = (PAIR_MODE != 0) ? N_SW / 2 : N_SW;

  logic [N_SEL-1:0] hit;

  for (genvar g = 0; g < N_SEL; g++) begin : g_hit
    assign hit[g] = held_en && (held_addr == AW'(g));
  end

  if (PAIR_MODE != 0) begin : g_pair
    assign want = {hit, hit};
  end else begin : g_single
    assign want = hit;
  end

endmodule

// File: rtl/chsel_bbm.sv
module chsel_bbm #(
  parameter int N_SW        = 8,
  parameter int DEAD_CYCLES = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_SW-1:0] want,
  output logic [N_SW-1:0] sw_close
);

  localparam int CNT_W = $clog2(DEAD_CYCLES + 1);

  logic [CNT_W-1:0] gap_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_close <= '0;
      gap_left <= '0;
    end else if (want == '0) begin
      sw_close <= '0;
      if (gap_left != '0) gap_left <= gap_left - 1'b1;
    end else if (want == sw_close) begin
      sw_close <= sw_close;
    end else if (sw_close != '0) begin
      sw_close <= '0;
      gap_left <= CNT_W'(DEAD_CYCLES - 1);
    end else if (gap_left != '0) begin
      gap_left <= gap_left - 1'b1;
    end else begin
      sw_close <= want;
    end
  end

endmodule

// File: rtl/chsel_timing.sv
module chsel_timing #(
  parameter int AW   = 3,
  parameter int T_WR = 10,
  parameter int T_SU = 10,
  parameter int T_HD = 1,
  parameter int T_RS = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] sel_addr,
  input  logic          sel_en,
  input  logic          wr_n,
  input  logic          clr_n,
  output logic          timing_err
);

  localparam int CMAX = chsel_pkg::max4(T_WR, T_SU, T_HD, T_RS);
  localparam int CW   = $clog2(CMAX + 1) + 1;
  localparam logic [CW-1:0] TOP = CW'(CMAX);

  logic [AW:0]   now_in, prev_in, cap_in;
  logic          wr_q, clr_q, rise;
  logic [CW-1:0] low_cnt, stab_cnt, clr_cnt, hold_left;

  assign now_in = {sel_addr, sel_en};
  assign rise   = !wr_q && wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q       <= 1'b1;
      clr_q      <= 1'b1;
      prev_in    <= '0;
      cap_in     <= '0;
      low_cnt    <= '0;
      stab_cnt   <= '0;
      clr_cnt    <= '0;
      hold_left  <= '0;
      timing_err <= 1'b0;
    end else begin
      wr_q    <= wr_n;
      clr_q   <= clr_n;
      prev_in <= now_in;
      low_cnt <= wr_n ? '0 : ((low_cnt == TOP) ? TOP : low_cnt + 1'b1);
      clr_cnt <= clr_n ? '0 : ((clr_cnt == TOP) ? TOP : clr_cnt + 1'b1);
      if (now_in != prev_in) stab_cnt <= CW'(1);
      else if (stab_cnt != TOP) stab_cnt <= stab_cnt + 1'b1;

      if (rise) begin
        cap_in    <= prev_in;
        hold_left <= CW'(T_HD - 1);
        if (low_cnt < CW'(T_WR) || stab_cnt < CW'(T_SU) || now_in != prev_in)
          timing_err <= 1'b1;
      end else if (hold_left != '0) begin
        hold_left <= hold_left - 1'b1;
        if (now_in != cap_in) timing_err <= 1'b1;
      end

      if (!clr_q && clr_n && clr_cnt < CW'(T_RS)) timing_err <= 1'b1;
    end
  end

endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl #(
  parameter int N_SW        = 8,
  parameter int PAIR_MODE   = 0,
  parameter int DEAD_CYCLES = 3,
  parameter int T_WR        = 10,
  parameter int T_SU        = 10,
  parameter int T_HD        = 1,
  parameter int T_RS        = 10,
  localparam int AW         = chsel_pkg::code_width(N_SW, PAIR_MODE)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   sel_addr,
  input  logic            sel_en,
  input  logic            wr_n,
  input  logic            clr_n,
  output logic [N_SW-1:0] sw_close,
  output logic            timing_err
);

  logic [AW-1:0]   held_addr;
  logic            held_en;
  logic [N_SW-1:0] want;

  chsel_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst(rst), .sel_addr(sel_addr), .sel_en(sel_en),
    .wr_n(wr_n), .clr_n(clr_n), .held_addr(held_addr), .held_en(held_en)
  );

  chsel_decode #(.N_SW(N_SW), .PAIR_MODE(PAIR_MODE), .AW(AW)) u_dec (
    .held_addr(held_addr), .held_en(held_en), .want(want)
  );

  chsel_bbm #(.N_SW(N_SW), .DEAD_CYCLES(DEAD_CYCLES)) u_bbm (
    .clk(clk), .rst(rst), .want(want), .sw_close(sw_close)
  );

  chsel_timing #(.AW(AW), .T_WR(T_WR), .T_SU(T_SU), .T_HD(T_HD), .T_RS(T_RS)) u_tim (
    .clk(clk), .rst(rst), .sel_addr(sel_addr), .sel_en(sel_en),
    .wr_n(wr_n), .clr_n(clr_n), .timing_err(timing_err)
  );

endmodule

// File: rtl/chsel_ctrl_chk.sv
module chsel_ctrl_chk #(
  parameter int N_SW      = 8,
  parameter int PAIR_MODE = 0,
  parameter int AW        = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   sel_addr,
  input logic            sel_en,
  input logic            wr_n,
  input logic            clr_n,
  input logic [N_SW-1:0] sw_close,
  input logic            timing_err
);

  logic [AW-1:0] unused_addr;
  assign unused_addr = sel_addr;

  if (PAIR_MODE != 0) begin : g_pair_chk
    assert_pair_R2: assert property (@(posedge clk) disable iff (rst)
      (sw_close[N_SW/2-1:0] == sw_close[N_SW-1:N_SW/2]) &&
      ($countones(sw_close) <= 2));
  end else begin : g_single_chk
    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sw_close));
  end

  assert_en_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !sel_en) |-> ##2 (sw_close == '0));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr_n) |-> ##2 (sw_close == '0));

  assert_bbm_R7: assert property (@(posedge clk) disable iff (rst)
    (sw_close != '0) |=> (sw_close == '0 || sw_close == $past(sw_close)));

  assert_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    timing_err |=> timing_err);

endmodule

bind chsel_ctrl chsel_ctrl_chk #(.N_SW(N_SW), .PAIR_MODE(PAIR_MODE), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .sel_addr(sel_addr), .sel_en(sel_en), .wr_n(wr_n),
  .clr_n(clr_n), .sw_close(sw_close), .timing_err(timing_err)
);

// File: tb/sim_chsel_ctrl.sv
module sim_chsel_ctrl;
  localparam int DEAD   = 3;
  localparam int WR_LOW = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       en = 1'b0, wr_n = 1'b1, clr_n = 1'b1;
  logic [7:0] sw0, sw1;
  logic       err0, err1;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  chsel_ctrl #(.PAIR_MODE(0), .DEAD_CYCLES(DEAD)) u0 (
    .clk(clk), .rst(rst), .sel_addr(addr), .sel_en(en), .wr_n(wr_n),
    .clr_n(clr_n), .sw_close(sw0), .timing_err(err0));

  chsel_ctrl #(.PAIR_MODE(1), .DEAD_CYCLES(DEAD)) u1 (
    .clk(clk), .rst(rst), .sel_addr(addr[1:0]), .sel_en(en), .wr_n(wr_n),
    .clr_n(clr_n), .sw_close(sw1), .timing_err(err1));

  function automatic logic [7:0] exp_single(input int a, input bit e);
    return e ? 8'(1 << a) : 8'h00;
  endfunction

  function automatic logic [7:0] exp_pair(input int a, input bit e);
    return e ? 8'((1 << (a % 4)) | (1 << (a % 4 + 4))) : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_n = 1'b1; clr_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input int a, input bit e);
    @(negedge clk); addr = 3'(a); en = e; wr_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4 transparent u0", sw0, exp_single(a, e));
    chk("R4 transparent u1", sw1, exp_pair(a, e));
    repeat (WR_LOW - 8) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic gap_run(input int b, output int z0, output int z1);
    z0 = 0; z1 = 0;
    @(negedge clk); addr = 3'(b); en = 1'b1; wr_n = 1'b0;
    for (int i = 0; i < WR_LOW; i++) begin
      @(negedge clk);
      if (sw0 == 8'h00) z0++;
      if (sw1 == 8'h00) z1++;
    end
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int z0, z1;
    do_reset();
    chk("R13 reset outputs u0", sw0, 8'h00);
    chk("R13 reset outputs u1", sw1, 8'h00);
    chk("R13 reset err", {6'b0, err1, err0}, 8'h00);

    // R1 R2 R3: sweep every code with enable on and off
    for (int a = 0; a < 8; a++) begin
      for (int e = 0; e < 2; e++) begin
        do_write(a, e[0]);
        chk(e ? "R1 decode single" : "R3 disabled single", sw0, exp_single(a, e[0]));
        chk(e ? "R2 decode pair" : "R3 disabled pair", sw1, exp_pair(a, e[0]));
      end
    end
    chk("R9 R10 R11 no false error", {6'b0, err1, err0}, 8'h00);

    // R5: inputs change while strobe high
    do_write(3, 1'b1);
    @(negedge clk); addr = 3'd6; en = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 hold single", sw0, exp_single(3, 1'b1));
    chk("R5 hold pair", sw1, exp_pair(3, 1'b1));

    // R3: disable opens after two edges with no gap
    @(negedge clk); addr = 3'd3; en = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    chk("R3 still closed after one edge", sw0, exp_single(3, 1'b1));
    @(negedge clk);
    chk("R3 open after two edges", sw0, 8'h00);
    // R8: empty to non-empty closes with no gap
    addr = 3'd5; en = 1'b1;
    @(negedge clk);
    chk("R8 not yet closed", sw0, 8'h00);
    @(negedge clk);
    chk("R8 closes at two edges", sw0, exp_single(5, 1'b1));
    chk("R8 closes at two edges pair", sw1, exp_pair(5, 1'b1));
    repeat (WR_LOW) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: gap between different selections
    do_write(1, 1'b1);
    gap_run(6, z0, z1);
    chk("R7 gap single", 8'(z0), 8'(DEAD));
    chk("R7 gap pair", 8'(z1), 8'(DEAD));
    chk("R7 final single", sw0, exp_single(6, 1'b1));
    chk("R7 final pair", sw1, exp_pair(6, 1'b1));
    do_write(1, 1'b1);
    gap_run(5, z0, z1);
    chk("R7 same pair no gap", 8'(z1), 8'd0);
    chk("R7 gap single other", 8'(z0), 8'(DEAD));

    // R6: clear overrides write, stays cleared
    do_write(2, 1'b1);
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R6 clear opens", sw0, 8'h00);
    addr = 3'd4; en = 1'b1; wr_n = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6 clear overrides write", sw0, 8'h00);
    chk("R6 clear overrides write pair", sw1, 8'h00);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R6 stays cleared", sw0, 8'h00);
    chk("R6 stays cleared pair", sw1, 8'h00);
    chk("R12 long clear no error", {6'b0, err1, err0}, 8'h00);

    // R9: short write pulse
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 short write", {7'b0, err0}, 8'h01);
    repeat (4) @(negedge clk);
    chk("R13 sticky", {7'b0, err0}, 8'h01);
    do_reset();
    chk("R13 reset clears err", {6'b0, err1, err0}, 8'h00);

    // R10: setup too short
    @(negedge clk); wr_n = 1'b0;
    repeat (12) @(negedge clk);
    addr = 3'd7;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 setup", {7'b0, err0}, 8'h01);
    do_reset();

    // R11: hold broken at strobe rise
    @(negedge clk); wr_n = 1'b0;
    repeat (12) @(negedge clk);
    wr_n = 1'b1; addr = 3'd1;
    repeat (2) @(negedge clk);
    chk("R11 hold", {7'b0, err0}, 8'h01);
    do_reset();

    // R12: short clear pulse
    @(negedge clk); clr_n = 1'b0;
    repeat (3) @(negedge clk);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 short clear", {7'b0, err0}, 8'h01);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule